// File: doc/BRIEF.md
# Normalized Newton-Raphson Reciprocal Unit

This unit computes the reciprocal of a positive depth value for a perspective divide. Operand and result are 24-bit two's-complement fixed-point numbers with 12 fractional bits and 11 integer bits above the sign. The operand is first raised to a floor of 8 raw units (0.001953125), so depths at or near zero cannot overflow the result. The clamped value is then shifted until its leading one becomes a mantissa in [1,2), and the shift count is kept.

A lookup table gives a first estimate of 1/mantissa. The table is addressed by the 10 mantissa bits just below the leading one, and its contents are computed at elaboration. Two Newton steps of the form x' = x·(2 − m·x) refine the estimate, with each product truncated to 23 fractional bits. The kept shift then scales the refined value back, giving 1/operand.

The unit works over several cycles and shares one multiplier. A caller pulses `start` with the operand while the unit is idle, then waits for the one-cycle `done` pulse that marks a valid `result`. The block applies no back-pressure on its output. A result is offered for one cycle and then held on `result` until the next `done`, so a consumer that needs it later reads it from there. An operand offered while `busy` is high is dropped, and the caller must hold it until `busy` is low.

Top module: `recip_nr_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and `result` is zero.
- R2: A `start` pulse while `busy` is low captures `operand`, and `busy` is high in the next cycle.
- R3: A `start` pulse while `busy` is high is ignored. It produces no extra `done`, and the result in progress still belongs to the operand captured first.
- R4: `done` is high for exactly one cycle, and `busy` is low in that cycle. `result` changes only in a cycle where `done` is high, and holds its value until the next `done`.
- R5: Each operation keeps `busy` high for 2 + 2·N_ITER cycles. With the defaults, `done` is high in the 7th cycle after the cycle in which `start` was sampled.
- R6: Any operand below 8 raw units in signed comparison is treated as 8. This covers zero and negative values, and gives a result of 2^21 raw (512.0) within the R7 tolerance.
- R7: For every operand a ≥ 8 raw, the raw result r satisfies |r − 2^24/a| ≤ (2^24/a)·2^-10 + 1.
- R8: On `done`, `result` is non-zero and not larger than 2^21 raw.
- R9: An operand that is an exact power of two, 2^k raw for each k from 3 to 22, gives a result within the R7 tolerance. This exercises every normalization shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Pulse requesting a new reciprocal; ignored while busy |
| operand | input | 24 | Depth value, signed, 12 fractional bits |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | 24 | Reciprocal of the clamped operand, signed, 12 fractional bits |

## Verification
The bench applies three kinds of operand. Every power of two from 8 to 2^22 separates faults in the leading-one search and the scale-back shift. Values below the floor (zero, one, seven and negative numbers) show whether the clamp uses a signed compare. Several hundred random operands of random magnitude test the table estimate and the Newton arithmetic against a real-valued reciprocal. A second start issued during a running operation shows whether the capture register is protected while busy. Measuring the latency and the pulse width of every `done` reveals faults in the sequencer.

// File: rtl/recip_nr_pkg.sv
package recip_nr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_MULA,
    ST_MULB,
    ST_FIN
  } recip_state_e;

  // Rounded estimate of 1/m for the midpoint of table cell idx,
  // m in [1,2), result scaled by 2^wf.
  function automatic longint unsigned seed_value(input int idx, input int aw, input int wf);
    longint unsigned num;
    longint unsigned den;
    num = longint'(1) << (wf + aw + 1);
    den = (longint'(1) << (aw + 1)) + longint'(2 * idx + 1);
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/recip_nr_norm.sv
module recip_nr_norm #(
  parameter int DW = 24,
  parameter int WF = 23,
  parameter int PW = 5
) (
  input  logic [DW-1:0] val,
  output logic [WF:0]   mant,
  output logic [PW-1:0] lead
);
  localparam int EW = DW + WF + 1;

  logic [EW-1:0] wide;

  always_comb begin
    lead = '0;
    for (int i = 0; i < DW; i++) begin
      if (val[i]) lead = PW'(i);
    end
  end

  always_comb begin
    wide = (EW'(val) << WF) >> lead;
    mant = (WF+1)'(wide);
  end

endmodule

// File: rtl/recip_nr_seed_rom.sv
module recip_nr_seed_rom #(
  parameter int AW = 10,
  parameter int WF = 23
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [WF:0]   data
);
  localparam int DEPTH = 1 << AW;

  logic [WF:0] table_c [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign table_c[g] = (WF+1)'(recip_nr_pkg::seed_value(g, AW, WF));
  end

  always_ff @(posedge clk) begin
    data <= table_c[addr];
  end

endmodule

// File: rtl/recip_nr_mul.sv
module recip_nr_mul #(
  parameter int OW = 25,
  parameter int WF = 23
) (
  input  logic [OW-1:0] a,
  input  logic [OW-1:0] b,
  output logic [OW-1:0] p
);
  logic [2*OW-1:0] full;

  assign full = {{OW{1'b0}}, a} * {{OW{1'b0}}, b};
  assign p    = OW'(full >> WF);

endmodule

// File: rtl/recip_nr_unit.sv
module recip_nr_unit #(
  parameter int DW     = 24,
  parameter int FW     = 12,
  parameter int WF     = 23,
  parameter int ROM_AW = 10,
  parameter int N_ITER = 2,
  parameter int MIN_OP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] operand,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  import recip_nr_pkg::*;

  localparam int MW  = WF + 2;
  localparam int PW  = $clog2(DW);
  localparam int ITW = $clog2(N_ITER + 1);
  localparam int XW  = DW + WF + 1;
  localparam logic [MW-1:0] TWO = MW'(1) << (WF + 1);

  recip_state_e  state_q;
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] opnd_c;
  logic [WF:0]   mant_c;
  logic [PW-1:0] lead_c;
  logic [WF:0]   mant_q;
  logic [PW-1:0] lead_q;
  logic [WF:0]   seed_q;
  logic [WF:0]   x_q;
  logic [WF:0]   x_cur;
  logic [MW-1:0] t_q;
  logic [MW-1:0] mul_a;
  logic [MW-1:0] mul_b;
  logic [MW-1:0] mul_p;
  logic [ITW-1:0] it_q;
  logic [DW-1:0] res_q;
  logic [DW-1:0] res_c;
  logic          done_q;
  logic [XW-1:0] xwide;
  int            sh_amt;

  // floor on the operand, signed compare so negatives clamp too
  always_comb begin
    if ($signed(operand) < $signed(DW'(MIN_OP))) opnd_c = DW'(MIN_OP);
    else                                          opnd_c = operand;
  end

  recip_nr_norm #(.DW(DW), .WF(WF), .PW(PW)) u_norm (
    .val  (opnd_q),
    .mant (mant_c),
    .lead (lead_c)
  );

  recip_nr_seed_rom #(.AW(ROM_AW), .WF(WF)) u_rom (
    .clk  (clk),
    .addr (mant_c[WF-1 -: ROM_AW]),
    .data (seed_q)
  );

  assign x_cur = (it_q == '0) ? seed_q : x_q;

  // one shared multiplier: m*x in MULA, x*(2-t) in MULB
  always_comb begin
    if (state_q == ST_MULB) begin
      mul_a = MW'(x_cur);
      mul_b = TWO - t_q;
    end else begin
      mul_a = MW'(mant_q);
      mul_b = MW'(x_cur);
    end
  end

  recip_nr_mul #(.OW(MW), .WF(WF)) u_mul (
    .a (mul_a),
    .b (mul_b),
    .p (mul_p)
  );

  // undo normalization: raw result = x * 2^(2FW - WF - lead)
  always_comb begin
    sh_amt = int'(lead_q) + WF - 2 * FW;
    xwide  = XW'(x_q);
    if (sh_amt >= 0) res_c = DW'(xwide >> sh_amt);
    else             res_c = DW'(xwide << (-sh_amt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      opnd_q  <= '0;
      mant_q  <= '0;
      lead_q  <= '0;
      x_q     <= '0;
      t_q     <= '0;
      it_q    <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            opnd_q  <= opnd_c;
            state_q <= ST_NORM;
          end
        end
        ST_NORM: begin
          mant_q  <= mant_c;
          lead_q  <= lead_c;
          it_q    <= '0;
          state_q <= ST_MULA;
        end
        ST_MULA: begin
          t_q     <= mul_p;
          state_q <= ST_MULB;
        end
        ST_MULB: begin
          x_q <= mul_p[WF:0];
          if (it_q == ITW'(N_ITER - 1)) begin
            state_q <= ST_FIN;
          end else begin
            it_q    <= it_q + 1'b1;
            state_q <= ST_MULA;
          end
        end
        ST_FIN: begin
          res_q   <= res_c;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

endmodule

// File: rtl/recip_nr_checker.sv
module recip_nr_checker #(
  parameter int DW     = 24,
  parameter int FW     = 12,
  parameter int N_ITER = 2,
  parameter int MIN_OP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result
);
  localparam int LAT = 2 + 2 * N_ITER;
  localparam longint BOUND = (longint'(1) << (2 * FW)) / MIN_OP;

  logic [7:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result))); // R4

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == 8'(LAT))); // R5

  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result != '0) && (result <= DW'(BOUND)))); // R8

endmodule

bind recip_nr_unit recip_nr_checker #(
  .DW(DW), .FW(FW), .N_ITER(N_ITER), .MIN_OP(MIN_OP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .result(result)
);

// File: tb/recip_nr_unit_tb.sv
module recip_nr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] operand = '0;
  logic        busy;
  logic        done;
  logic [23:0] result;

  int n_vec = 0;
  int n_bad = 0;
  int n_done = 0;
  int n_push = 0;
  bit finished = 1'b0;
  logic [23:0] exp_q[$];

  always #10 clk = ~clk;

  recip_nr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .busy(busy), .done(done), .result(result)
  );

  function automatic int clamp_op(input logic [23:0] op);
    int sv;
    sv = int'($signed(op));
    return (sv < 8) ? 8 : sv;
  endfunction

  task automatic check(input bit ok, input string req, input real got, input real expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0f expected %0f", req, got, expv);
    end
  endtask

  // driver: one operation, pushes the operand, checks R2 and R5
  task automatic send(input logic [23:0] op, input bit intrude, input logic [23:0] op2);
    int n;
    while (busy) @(negedge clk);
    operand = op;
    start = 1'b1;
    exp_q.push_back(op);
    n_push++;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(busy == 1'b1, "R2 busy after start", real'(busy), 1.0);
    while (!done && n < 50) begin
      if (intrude && n == 2) begin
        operand = op2;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n == 7, "R5 latency", real'(n), 7.0);
  endtask

  // monitor: pops the scoreboard on each done
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        logic [23:0] op;
        logic [23:0] got;
        real ex;
        real diff;
        int ac;
        n_done++;
        got = result;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected done", real'(got), 0.0);
        end else begin
          op = exp_q.pop_front();
          ac = clamp_op(op);
          ex = 16777216.0 / real'(ac);
          diff = real'(got) - ex;
          if (diff < 0.0) diff = -diff;
          if (ac == 8 && int'($signed(op)) < 8)
            check(diff <= ex / 1024.0 + 1.0, "R6 clamp", real'(got), ex);
          else
            check(diff <= ex / 1024.0 + 1.0, "R7 accuracy", real'(got), ex);
          check(got != 0 && got <= 24'd2097152, "R8 range", real'(got), ex);
          check(busy == 1'b0, "R4 busy low with done", real'(busy), 0.0);
        end
        @(negedge clk);
        check(done == 1'b0, "R4 done one cycle", real'(done), 0.0);
        check(result == got, "R4 result held", real'(result), real'(got));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset flags", real'({busy, done}), 0.0);
    check(result == '0, "R1 reset result", real'(result), 0.0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: every power of two
    for (int k = 3; k <= 22; k++) send(24'(1) << k, 1'b0, '0);

    // R6: values below the floor
    send(24'd0, 1'b0, '0);
    send(24'd1, 1'b0, '0);
    send(24'd7, 1'b0, '0);
    send(24'hFFFFFF, 1'b0, '0);
    send(24'h800000, 1'b0, '0);
    send(24'd9, 1'b0, '0);
    send(24'h7FFFFF, 1'b0, '0);

    // R3: second start during an operation is dropped
    send(24'd4096, 1'b1, 24'd12345);
    repeat (12) @(negedge clk);
    check(n_done == n_push, "R3 no extra done", real'(n_done), real'(n_push));
    send(24'd300000, 1'b1, 24'd8);

    // R7: random operands of random magnitude
    for (int i = 0; i < 400; i++) begin
      int sh;
      logic [23:0] v;
      sh = int'($urandom_range(0, 20));
      v = 24'($urandom) & 24'h7FFFFF;
      v = v >> sh;
      send(v, 1'b0, '0);
    end

    repeat (12) @(negedge clk);
    check(n_done == n_push, "R3 done count", real'(n_done), real'(n_push));
    check(exp_q.size() == 0, "R3 scoreboard drained", real'(exp_q.size()), 0.0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule